// File: doc/BRIEF.md
# Timestamp-Isolated Cache Tag Array

This block is the tag and state store of a small direct-mapped cache that several hardware contexts share. It decides hit or miss from tag and state alone. It blocks the reuse channel between contexts. A context that touches a line some other context brought in always sees a miss on that first touch. After that touch, later accesses by the same context may hit.

Every line carries a tag, a valid flag, a load timestamp and one ownership bit per context. A lookup hits only when the line is valid, the tag matches and the requester's bit is set. A fill, or a tag match whose bit is clear, stamps the line with the global time. It gives the line to the requester alone. A global time counter steps once for each cycle in which an access or a fill is accepted. When the counter wraps to zero, every ownership bit is wiped.

Contexts are switched out and in through a separate port. Switch-out records the current time for that context. Switch-in starts a bit-serial sweep, most significant bit first, over all lines at once. The sweep removes the incoming context's bit from every line stamped later than its recorded time. While the sweep runs, `busy` is high and every request is dropped.

Top module: `tic_tag_array`

## Requirements
- R1: After reset, no line is valid, no ownership bit is set, the time counter and all recorded times are zero and `busy` is low, so any access misses.
- R2: An accepted access (`acc_valid` high while `busy` is low) produces `rsp_valid` exactly one cycle later. `rsp_hit` is 1 only if the indexed line is valid, its tag equals the address tag and the requester's ownership bit is set.
- R3: An accepted fill makes the indexed line valid with the new tag and stamps it with the current time. It sets the filler's ownership bit and clears every other context's bit.
- R4: An access whose tag matches but whose ownership bit is clear reports a miss. It then restamps the line and gives ownership to the requester alone. The next access by that context hits, and the previous owner's next access misses.
- R5: Switch-out of a context records the current time for it. A later switch-in of that context clears its ownership bit on every line whose timestamp is strictly greater than the recorded time. A line stamped with a time equal to the recorded time keeps the bit.
- R6: A switch-in raises `busy` from the next cycle for exactly TS_W cycles. While `busy` is high, accesses, fills and switch requests are dropped: they give no response, change no line and do not advance time.
- R7: When an access and a fill are accepted in the same cycle, the lookup uses the line state from before that cycle. If both hit the same index, the fill's update wins.
- R8: The time counter advances by one in each cycle with an accepted access, fill or both. On the step from all-ones to zero, every ownership bit in the array is cleared.
- R9: The line index is address bits [IDX_W-1:0] (bits [3:0] by default). The tag is the remaining upper bits. A different tag at the same index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Lookup request |
| acc_ctx | input | CTX_W (2) | Requesting context |
| acc_addr | input | ADDR_W (12) | Lookup line address |
| rsp_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| fill_valid | input | 1 | Install request |
| fill_ctx | input | CTX_W (2) | Context that owns the filled line |
| fill_addr | input | ADDR_W (12) | Line address being installed |
| swout_valid | input | 1 | Context leaves the core |
| swout_ctx | input | CTX_W (2) | Context leaving |
| swin_valid | input | 1 | Context enters the core; starts the sweep |
| swin_ctx | input | CTX_W (2) | Context entering |
| busy | output | 1 | Sweep in progress; requests dropped |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a lookup and a fill to the same index. The bench drives both in one cycle against a line whose ownership would give a hit. It expects the hit, taken from the old state, and then expects the old owner to miss and the filler to hit. The second pair is a request and a running sweep. In the middle of the sweep the bench drives an access and a fill, and it judges them by the missing response and by a later miss on the line the dropped fill aimed at. The counter wrap is placed on an ordinary access, and the sweep boundary is tested with a line stamped at exactly the recorded time.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int unsigned DEF_LINES  = 16;
    localparam int unsigned DEF_CTX    = 4;
    localparam int unsigned DEF_TS_W   = 8;
    localparam int unsigned DEF_ADDR_W = 12;

    typedef enum logic {
        SWP_IDLE = 1'b0,
        SWP_RUN  = 1'b1
    } swp_state_e;

    // One MSB-first magnitude step: returns {still_equal, line_greater}
    function automatic logic [1:0] cmp_step(input logic eq_in, input logic gt_in,
                                            input logic line_bit, input logic ref_bit);
        logic eq_out;
        logic gt_out;
        eq_out = eq_in & ~(line_bit ^ ref_bit);
        gt_out = gt_in | (eq_in & line_bit & ~ref_bit);
        return {eq_out, gt_out};
    endfunction

endpackage

// File: rtl/tic_time.sv
module tic_time #(
    parameter int unsigned CTX  = tic_pkg::DEF_CTX,
    parameter int unsigned TS_W = tic_pkg::DEF_TS_W,
    localparam int unsigned CTX_W = (CTX > 1) ? $clog2(CTX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             save_go,
    input  logic [CTX_W-1:0] save_ctx,
    output logic [TS_W-1:0]  now,
    output logic             wrap,
    output logic [TS_W-1:0]  saved [CTX]
);

    assign wrap = step && (now == {TS_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (step) begin
            now <= now + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < CTX; c++) saved[c] <= '0;
        end else if (save_go) begin
            saved[save_ctx] <= now;
        end
    end

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> now == ($past(now) + 1'b1)); // R8
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(now)); // R8
    AST_SAVE_TIME: assert property (@(posedge clk) disable iff (rst)
        save_go |=> saved[$past(save_ctx)] == $past(now)); // R5

endmodule

// File: rtl/tic_sweep.sv
module tic_sweep
    import tic_pkg::*;
#(
    parameter int unsigned LINES = DEF_LINES,
    parameter int unsigned CTX   = DEF_CTX,
    parameter int unsigned TS_W  = DEF_TS_W,
    localparam int unsigned CTX_W = (CTX > 1) ? $clog2(CTX) : 1,
    localparam int unsigned BIT_W = (TS_W > 1) ? $clog2(TS_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CTX_W-1:0] start_ctx,
    input  logic [TS_W-1:0]  saved [CTX],
    input  logic [TS_W-1:0]  line_ts [LINES],
    output logic             busy,
    output logic [LINES-1:0] clr,
    output logic [CTX_W-1:0] clr_ctx
);

    swp_state_e         st_q;
    logic [BIT_W-1:0]   cnt_q;
    logic [TS_W-1:0]    ref_q;
    logic [CTX_W-1:0]   ctx_q;
    logic [LINES-1:0]   eq_q;
    logic [LINES-1:0]   gt_q;
    logic [1:0]         stp [LINES];
    logic               last;

    assign busy    = (st_q == SWP_RUN);
    assign last    = busy && (cnt_q == '0);
    assign clr_ctx = ctx_q;

    for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign stp[i] = cmp_step(eq_q[i], gt_q[i], line_ts[i][cnt_q], ref_q[cnt_q]);
        assign clr[i] = last && stp[i][0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SWP_IDLE;
            cnt_q <= '0;
            ref_q <= '0;
            ctx_q <= '0;
        end else if (start && !busy) begin
            st_q  <= SWP_RUN;
            cnt_q <= BIT_W'(TS_W - 1);
            ref_q <= saved[start_ctx];
            ctx_q <= start_ctx;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
            if (last) st_q <= SWP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q <= '0;
            gt_q <= '0;
        end else if (start && !busy) begin
            eq_q <= '1;
            gt_q <= '0;
        end else if (busy) begin
            for (int i = 0; i < LINES; i++) begin
                eq_q[i] <= stp[i][1];
                gt_q[i] <= stp[i][0];
            end
        end
    end

    AST_SWEEP_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy && (cnt_q == BIT_W'(TS_W - 1))); // R6
    AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != '0) |=> busy); // R6
    AST_SWEEP_END: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q == '0) |=> !busy); // R6

endmodule

// File: rtl/tic_lines.sv
module tic_lines #(
    parameter int unsigned LINES = tic_pkg::DEF_LINES,
    parameter int unsigned CTX   = tic_pkg::DEF_CTX,
    parameter int unsigned TS_W  = tic_pkg::DEF_TS_W,
    parameter int unsigned TAG_W = 8,
    localparam int unsigned CTX_W = (CTX > 1) ? $clog2(CTX) : 1,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_go,
    input  logic [CTX_W-1:0] acc_ctx,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             fill_go,
    input  logic [CTX_W-1:0] fill_ctx,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [TS_W-1:0]  now,
    input  logic             wrap,
    input  logic [LINES-1:0] clr,
    input  logic [CTX_W-1:0] clr_ctx,
    output logic             hit,
    output logic [TS_W-1:0]  line_ts [LINES]
);

    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [CTX-1:0]   own_q [LINES];
    logic             tag_eq;
    logic             steal;
    logic             any_own;

    assign tag_eq = vld_q[acc_idx] && (tag_q[acc_idx] == acc_tag);
    assign hit    = tag_eq && own_q[acc_idx][acc_ctx];
    assign steal  = acc_go && tag_eq && !own_q[acc_idx][acc_ctx];

    always_comb begin
        any_own = 1'b0;
        for (int i = 0; i < LINES; i++) any_own = any_own | (|own_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]   <= '0;
                own_q[i]   <= '0;
                line_ts[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (steal && acc_idx == IDX_W'(i)) begin
                    line_ts[i] <= now;
                    own_q[i]   <= CTX'(1) << acc_ctx;
                end
                if (fill_go && fill_idx == IDX_W'(i)) begin
                    vld_q[i]   <= 1'b1;
                    tag_q[i]   <= fill_tag;
                    line_ts[i] <= now;
                    own_q[i]   <= CTX'(1) << fill_ctx;
                end
                if (clr[i]) own_q[i][clr_ctx] <= 1'b0;
                if (wrap) own_q[i] <= '0;
            end
        end
    end

    AST_FILL_OWNS: assert property (@(posedge clk) disable iff (rst)
        (fill_go && !wrap) |=> own_q[$past(fill_idx)] == (CTX'(1) << $past(fill_ctx))); // R3
    AST_FILL_STAMP: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> line_ts[$past(fill_idx)] == $past(now)); // R3
    AST_STEAL_OWNS: assert property (@(posedge clk) disable iff (rst)
        (steal && !wrap && !(fill_go && fill_idx == acc_idx))
        |=> own_q[$past(acc_idx)] == (CTX'(1) << $past(acc_ctx))); // R4
    AST_WRAP_WIPES: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !any_own); // R8

endmodule

// File: rtl/tic_tag_array.sv
module tic_tag_array #(
    parameter int unsigned LINES  = tic_pkg::DEF_LINES,
    parameter int unsigned CTX    = tic_pkg::DEF_CTX,
    parameter int unsigned TS_W   = tic_pkg::DEF_TS_W,
    parameter int unsigned ADDR_W = tic_pkg::DEF_ADDR_W,
    localparam int unsigned CTX_W = (CTX > 1) ? $clog2(CTX) : 1,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [CTX_W-1:0]  acc_ctx,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    input  logic              fill_valid,
    input  logic [CTX_W-1:0]  fill_ctx,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              swout_valid,
    input  logic [CTX_W-1:0]  swout_ctx,
    input  logic              swin_valid,
    input  logic [CTX_W-1:0]  swin_ctx,
    output logic              busy
);

    logic             acc_go;
    logic             fill_go;
    logic             save_go;
    logic             swin_go;
    logic             step;
    logic             wrap;
    logic             hit;
    logic [TS_W-1:0]  now;
    logic [TS_W-1:0]  saved   [CTX];
    logic [TS_W-1:0]  line_ts [LINES];
    logic [LINES-1:0] clr;
    logic [CTX_W-1:0] clr_ctx;

    assign acc_go  = acc_valid   && !busy;
    assign fill_go = fill_valid  && !busy;
    assign save_go = swout_valid && !busy;
    assign swin_go = swin_valid  && !busy;
    assign step    = acc_go || fill_go;

    tic_time #(.CTX(CTX), .TS_W(TS_W)) u_time (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .save_go  (save_go),
        .save_ctx (swout_ctx),
        .now      (now),
        .wrap     (wrap),
        .saved    (saved)
    );

    tic_sweep #(.LINES(LINES), .CTX(CTX), .TS_W(TS_W)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .start     (swin_go),
        .start_ctx (swin_ctx),
        .saved     (saved),
        .line_ts   (line_ts),
        .busy      (busy),
        .clr       (clr),
        .clr_ctx   (clr_ctx)
    );

    tic_lines #(.LINES(LINES), .CTX(CTX), .TS_W(TS_W), .TAG_W(TAG_W)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .acc_go   (acc_go),
        .acc_ctx  (acc_ctx),
        .acc_idx  (acc_addr[IDX_W-1:0]),
        .acc_tag  (acc_addr[ADDR_W-1:IDX_W]),
        .fill_go  (fill_go),
        .fill_ctx (fill_ctx),
        .fill_idx (fill_addr[IDX_W-1:0]),
        .fill_tag (fill_addr[ADDR_W-1:IDX_W]),
        .now      (now),
        .wrap     (wrap),
        .clr      (clr),
        .clr_ctx  (clr_ctx),
        .hit      (hit),
        .line_ts  (line_ts)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= acc_go;
            rsp_hit   <= acc_go && hit;
        end
    end

    AST_RSP_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_valid) && !$past(busy)); // R2
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        busy |=> now == $past(now)); // R6
    AST_NO_HIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit); // R2

endmodule

// File: tb/sim_tic_tag_array.sv
module sim_tic_tag_array;

    localparam int LINES = 16;
    localparam int CTX   = 4;
    localparam int TS_W  = 8;
    localparam int AW    = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_ctx = '0;
    logic [AW-1:0] acc_addr = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic          fill_valid = 1'b0;
    logic [1:0]    fill_ctx = '0;
    logic [AW-1:0] fill_addr = '0;
    logic          swout_valid = 1'b0;
    logic [1:0]    swout_ctx = '0;
    logic          swin_valid = 1'b0;
    logic [1:0]    swin_ctx = '0;
    logic          busy;

    always #2.5 clk = ~clk;

    tic_tag_array u0 (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_ctx(acc_ctx), .acc_addr(acc_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .fill_valid(fill_valid), .fill_ctx(fill_ctx), .fill_addr(fill_addr),
        .swout_valid(swout_valid), .swout_ctx(swout_ctx),
        .swin_valid(swin_valid), .swin_ctx(swin_ctx),
        .busy(busy)
    );

    int nvec  = 0;
    int nfail = 0;
    bit done  = 0;

    // requirement-level model
    bit       m_vld [LINES];
    int       m_tag [LINES];
    int       m_ts  [LINES];
    bit [3:0] m_own [LINES];
    int       m_now = 0;
    int       m_saved [CTX];

    bit    exp_q [$];
    string req_q [$];

    task automatic chk(input string r, input bit ok, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic int mk(input int tag, input int idx);
        return tag * LINES + idx;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < LINES; i++) begin
            m_vld[i] = 0; m_tag[i] = 0; m_ts[i] = 0; m_own[i] = '0;
        end
        for (int c = 0; c < CTX; c++) m_saved[c] = 0;
        m_now = 0;
    endtask

    // drive one cycle at a falling edge; push expected lookup result
    task automatic op(input string r, input bit av, input int ac, input int aa,
                      input bit fv, input int fc, input int fa);
        int ai, at, fi, ft;
        bit h;
        ai = aa % LINES; at = aa / LINES;
        fi = fa % LINES; ft = fa / LINES;
        acc_valid = av; acc_ctx = 2'(ac); acc_addr = AW'(aa);
        fill_valid = fv; fill_ctx = 2'(fc); fill_addr = AW'(fa);
        if (av) begin
            h = m_vld[ai] && m_tag[ai] == at && m_own[ai][ac];
            exp_q.push_back(h);
            req_q.push_back(r);
            if (m_vld[ai] && m_tag[ai] == at && !m_own[ai][ac]) begin
                m_ts[ai] = m_now; m_own[ai] = 4'(1 << ac);
            end
        end
        if (fv) begin
            m_vld[fi] = 1; m_tag[fi] = ft; m_ts[fi] = m_now; m_own[fi] = 4'(1 << fc);
        end
        if (av || fv) begin
            if (m_now == (1 << TS_W) - 1) begin
                for (int i = 0; i < LINES; i++) m_own[i] = '0;
            end
            m_now = (m_now + 1) % (1 << TS_W);
        end
        @(negedge clk);
        acc_valid = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic acc(input string r, input int c, input int a);
        op(r, 1, c, a, 0, 0, 0);
    endtask

    task automatic fill(input string r, input int c, input int a);
        op(r, 0, 0, 0, 1, c, a);
    endtask

    task automatic swout(input int c);
        swout_valid = 1'b1; swout_ctx = 2'(c);
        m_saved[c] = m_now;
        @(negedge clk);
        swout_valid = 1'b0;
    endtask

    // switch-in; mid-sweep an access and a fill are driven and must be dropped (R6)
    task automatic swin(input int c, input int drop_acc, input int drop_fill);
        swin_valid = 1'b1; swin_ctx = 2'(c);
        @(negedge clk);
        swin_valid = 1'b0;
        for (int k = 0; k < TS_W; k++) begin
            chk("R6 busy during sweep", busy == 1'b1, busy, 1);
            if (k == 3) begin
                acc_valid = 1'b1; acc_ctx = 2'(c); acc_addr = AW'(drop_acc);
                fill_valid = 1'b1; fill_ctx = 2'd0; fill_addr = AW'(drop_fill);
            end
            @(negedge clk);
            acc_valid = 1'b0; fill_valid = 1'b0;
        end
        chk("R6 busy drops after TS_W cycles", busy == 1'b0, busy, 0);
        for (int i = 0; i < LINES; i++)
            if (m_ts[i] > m_saved[c]) m_own[i][c] = 1'b0;
    endtask

    // monitor: pops expected lookup results as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2/R6 unexpected response", 1'b0, 1, 0);
            end else begin
                bit e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(r, rsp_hit == e, rsp_hit, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            nvec++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy low after reset", busy == 1'b0, busy, 0);
        chk("R1 no response after reset", rsp_valid == 1'b0, rsp_valid, 0);

        acc("R1 empty array misses", 0, mk(5, 1));

        fill("R3", 0, mk(5, 1));
        acc("R2 owner hits", 0, mk(5, 1));
        acc("R9 other tag same index misses", 0, mk(6, 1));
        acc("R9 same tag other index misses", 0, mk(5, 2));

        acc("R4 first touch by other context misses", 1, mk(5, 1));
        acc("R4 second touch hits", 1, mk(5, 1));
        acc("R4 previous owner now misses", 0, mk(5, 1));
        acc("R4 previous owner reclaims", 0, mk(5, 1));

        op("R7 lookup sees old state", 1, 0, mk(5, 1), 1, 2, mk(9, 1));
        acc("R7 fill won the line", 0, mk(5, 1));
        acc("R7 filler hits", 2, mk(9, 1));

        fill("R3", 3, mk(1, 3));
        swout(3);
        fill("R3", 3, mk(1, 4));
        fill("R3", 3, mk(1, 5));
        swin(3, mk(1, 3), mk(7, 6));
        acc("R5 older line kept", 3, mk(1, 3));
        acc("R5 equal timestamp kept", 3, mk(1, 4));
        acc("R5 newer line cleared", 3, mk(1, 5));
        acc("R6 dropped fill left line empty", 0, mk(7, 6));
        acc("R5 other context untouched", 2, mk(9, 1));

        fill("R3", 3, mk(2, 8));
        while (m_now != (1 << TS_W) - 2) acc("R8 filler miss", 0, mk(0, 15));
        acc("R8 hit before wrap", 3, mk(2, 8));
        acc("R8 wrapping access", 0, mk(0, 15));
        acc("R8 bits wiped at wrap", 3, mk(2, 8));
        acc("R8 reclaimed after wrap", 3, mk(2, 8));

        repeat (3) @(negedge clk);
        chk("R2 every lookup answered", exp_q.size() == 0, exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule